// File: doc/BRIEF.md
# Program Counter with High-Byte Latch

This block holds the 13-bit instruction address of a small 8-bit processor core. Normally it advances by one each instruction cycle on a step strobe. The core's decode logic can also redirect it in three ways: a jump (GOTO or CALL) carrying an 11-bit target, a write of the low address byte by an ALU instruction, or a load of a full address returned from the call stack.

The upper five address bits are never written directly. Software writes them into a separate 5-bit latch register. The latch is copied into the counter only when the low byte is written, or, in part, when a jump is taken. A computed jump (adding an offset to the low byte) therefore never carries into the upper bits. A table that crosses a 256-word boundary needs software to bump the latch.

The block also drives the return address of the current instruction, which an external stack stores on a call.

Top module: `pc_unit`

## Requirements
- R1: While rst_ni is low, and directly after it rises, pc_o is 0x0000 and latch_o is 0x00.
- R2: pc_low_o always equals pc_o[7:0].
- R3: A low-byte write (low_we_i) sets pc_o[7:0] to low_wdata_i and pc_o[12:8] to the five latch bits held before that cycle, on the next clock edge. This applies even when latch_we_i is high in the same cycle. Nothing carries from the low byte into the upper bits.
- R4: A jump (jump_i) sets pc_o[10:0] to jump_target_i and pc_o[12:11] to latch bits 4:3 on the next edge. A jump wins over every other request in the same cycle.
- R5: A pop load (pop_i) without a jump sets all 13 bits of pc_o to pop_addr_i. It wins over a low-byte write and over a step.
- R6: With step_i as the only request, pc_o increments by one and wraps from 0x1FFF to 0x0000.
- R7: With no request asserted, pc_o keeps its value.
- R8: latch_o changes only on latch_we_i, taking latch_wdata_i on the next edge. Jumps, pop loads, low-byte writes and steps leave it unchanged.
- R9: ret_addr_o always equals pc_o + 1 modulo 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Advance to the next sequential address |
| jump_i | input | 1 | Take a GOTO/CALL target |
| jump_target_i | input | 11 | Target field from the opcode |
| low_we_i | input | 1 | ALU result written to the low address byte |
| low_wdata_i | input | 8 | Low byte value |
| latch_we_i | input | 1 | Write the high latch |
| latch_wdata_i | input | 5 | High latch value |
| pop_i | input | 1 | Load the address returned by the stack |
| pop_addr_i | input | 13 | Popped address |
| pc_o | output | 13 | Current program counter |
| pc_low_o | output | 8 | Readable low byte of the counter |
| latch_o | output | 5 | High latch contents |
| ret_addr_o | output | 13 | Address to push on a call |

## Verification
The assertions make no assumption that the requests are mutually exclusive. Each one names the precedence it depends on: a low-byte load is checked only when neither jump nor pop is present, and an increment only when step is the sole request. The stimulus deliberately drives overlapping requests (jump with low write, pop with low write, latch write with low write) so that the precedence rules and the use of the old latch value are both exercised. All inputs are driven on the falling edge, so every request is stable at the rising edge that consumes it.

// File: rtl/pc_pkg.sv
package pc_pkg;
  parameter int unsigned PC_W    = 13;
  parameter int unsigned LOW_W   = 8;
  parameter int unsigned HI_W    = PC_W - LOW_W;
  parameter int unsigned TGT_W   = 11;
  parameter int unsigned JHI_W   = PC_W - TGT_W;
  typedef logic [PC_W-1:0]  pc_t;
  typedef logic [LOW_W-1:0] low_t;
  typedef logic [HI_W-1:0]  hi_t;
  typedef logic [TGT_W-1:0] tgt_t;
endpackage

// File: rtl/pc_flop.sv
module pc_flop #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/pc_incr.sv
module pc_incr #(
  parameter int unsigned W = 13
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  assign y_o = a_i + ONE; // wraps modulo 2**W
endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_pkg::*;
(
  input  pc_t  pc_q_i,
  input  pc_t  pc_inc_i,
  input  hi_t  latch_i,
  input  logic step_i,
  input  logic jump_i,
  input  tgt_t jump_target_i,
  input  logic low_we_i,
  input  low_t low_wdata_i,
  input  logic pop_i,
  input  pc_t  pop_addr_i,
  output pc_t  pc_d_o
);
  // priority: jump > pop > low write > step > hold
  always_comb begin
    if (jump_i)        pc_d_o = {latch_i[HI_W-1 -: JHI_W], jump_target_i};
    else if (pop_i)    pc_d_o = pop_addr_i;
    else if (low_we_i) pc_d_o = {latch_i, low_wdata_i};
    else if (step_i)   pc_d_o = pc_inc_i;
    else               pc_d_o = pc_q_i;
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                jump_i,
  input  logic [TGT_W-1:0]    jump_target_i,
  input  logic                low_we_i,
  input  logic [LOW_W-1:0]    low_wdata_i,
  input  logic                latch_we_i,
  input  logic [HI_W-1:0]     latch_wdata_i,
  input  logic                pop_i,
  input  logic [PC_W-1:0]     pop_addr_i,
  output logic [PC_W-1:0]     pc_o,
  output logic [LOW_W-1:0]    pc_low_o,
  output logic [HI_W-1:0]     latch_o,
  output logic [PC_W-1:0]     ret_addr_o
);
  pc_t pc_q, pc_d, pc_inc;
  hi_t latch_q, latch_d;

  assign latch_d = latch_we_i ? latch_wdata_i : latch_q;

  pc_flop #(.W(HI_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(latch_d), .q_o(latch_q)
  );

  pc_incr #(.W(PC_W)) u_incr (.a_i(pc_q), .y_o(pc_inc));

  pc_next_sel u_sel (
    .pc_q_i(pc_q), .pc_inc_i(pc_inc), .latch_i(latch_q),
    .step_i(step_i), .jump_i(jump_i), .jump_target_i(jump_target_i),
    .low_we_i(low_we_i), .low_wdata_i(low_wdata_i),
    .pop_i(pop_i), .pop_addr_i(pop_addr_i), .pc_d_o(pc_d)
  );

  pc_flop #(.W(PC_W)) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pc_d), .q_o(pc_q)
  );

  assign pc_o       = pc_q;
  assign pc_low_o   = pc_q[LOW_W-1:0];
  assign latch_o    = latch_q;
  assign ret_addr_o = pc_inc;

  AST_JUMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> pc_o == {$past(latch_o[HI_W-1 -: JHI_W]), $past(jump_target_i)}); // R4
  AST_POP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !jump_i) |=> pc_o == $past(pop_addr_i)); // R5
  AST_LOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_we_i && !jump_i && !pop_i) |=> pc_o == {$past(latch_o), $past(low_wdata_i)}); // R3
  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !jump_i && !pop_i && !low_we_i) |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !jump_i && !pop_i && !low_we_i) |=> $stable(pc_o)); // R7
  AST_LATCH_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we_i |=> $stable(latch_o)); // R8
  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we_i |=> latch_o == $past(latch_wdata_i)); // R8
endmodule

// File: tb/pc_unit_bench.sv
module pc_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 0, jump = 0, low_we = 0, latch_we = 0, pop = 0;
  logic [10:0] jtgt = '0;
  logic [7:0]  low_wd = '0;
  logic [4:0]  latch_wd = '0;
  logic [12:0] pop_addr = '0;
  logic [12:0] pc, ret;
  logic [7:0]  pcl;
  logic [4:0]  lat;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_unit u_pc_unit (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .jump_i(jump),
    .jump_target_i(jtgt), .low_we_i(low_we), .low_wdata_i(low_wd),
    .latch_we_i(latch_we), .latch_wdata_i(latch_wd), .pop_i(pop),
    .pop_addr_i(pop_addr), .pc_o(pc), .pc_low_o(pcl), .latch_o(lat),
    .ret_addr_o(ret)
  );

  task automatic chk(string req, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle();
    step = 0; jump = 0; low_we = 0; latch_we = 0; pop = 0;
  endtask

  // inputs set at negedge, one rising edge, sample at next negedge
  task automatic tick();
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic set_latch(logic [4:0] v);
    latch_we = 1; latch_wd = v; tick();
  endtask

  task automatic wr_low(logic [7:0] v);
    low_we = 1; low_wd = v; tick();
  endtask

  task automatic t_reset();
    chk("R1 pc in reset", pc, 13'h0000);
    chk("R1 latch in reset", {8'h0, lat}, 13'h0000);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 pc after reset", pc, 13'h0000);
    chk("R9 ret after reset", ret, 13'h0001);
  endtask

  task automatic t_step();
    for (int i = 0; i < 3; i++) begin step = 1; tick(); end
    chk("R6 step x3", pc, 13'h0003);
    chk("R2 low byte", {5'h0, pcl}, 13'h0003);
    chk("R9 ret", ret, 13'h0004);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) tick();
    chk("R7 hold", pc, 13'h0003);
  endtask

  task automatic t_low_write();
    set_latch(5'h0A);
    chk("R8 latch write", {8'h0, lat}, 13'h000A);
    chk("R8 latch write leaves pc", pc, 13'h0003);
    wr_low(8'h34);
    chk("R3 low write", pc, 13'h0A34);
    chk("R2 low byte", {5'h0, pcl}, 13'h0034);
    // same-cycle latch write: old latch used
    latch_we = 1; latch_wd = 5'h15; low_we = 1; low_wd = 8'h10; tick();
    chk("R3 old latch used", pc, 13'h0A10);
    chk("R8 new latch", {8'h0, lat}, 13'h0015);
  endtask

  task automatic t_no_carry();
    set_latch(5'h02);
    wr_low(8'hF0);
    chk("R3 load", pc, 13'h02F0);
    wr_low(8'hF0 + 8'h20); // computed jump result wraps in 8 bits
    chk("R3 no carry", pc, 13'h0210);
    step = 1; tick();
    wr_low(8'hFF); step = 1; tick();
    chk("R6 step carries", pc, 13'h0300);
  endtask

  task automatic t_jump();
    set_latch(5'h15);
    jump = 1; jtgt = 11'h123; tick();
    chk("R4 jump", pc, 13'h1123);
    chk("R8 latch after jump", {8'h0, lat}, 13'h0015);
    jump = 1; jtgt = 11'h7FF; low_we = 1; low_wd = 8'h00; pop = 1;
    pop_addr = 13'h0ABC; step = 1; tick();
    chk("R4 jump wins", pc, 13'h17FF);
  endtask

  task automatic t_pop();
    pop = 1; pop_addr = 13'h0ABC; tick();
    chk("R5 pop", pc, 13'h0ABC);
    chk("R8 latch after pop", {8'h0, lat}, 13'h0015);
    pop = 1; pop_addr = 13'h1357; low_we = 1; low_wd = 8'h99; step = 1; tick();
    chk("R5 pop over low write", pc, 13'h1357);
  endtask

  task automatic t_wrap();
    set_latch(5'h1F);
    wr_low(8'hFF);
    chk("R3 top address", pc, 13'h1FFF);
    chk("R9 ret wraps", ret, 13'h0000);
    step = 1; tick();
    chk("R6 wrap", pc, 13'h0000);
    chk("R8 latch kept", {8'h0, lat}, 13'h001F);
  endtask

  task automatic t_async_reset();
    #2 rst_n = 0; #1;
    chk("R1 async pc", pc, 13'h0000);
    chk("R1 async latch", {8'h0, lat}, 13'h0000);
    @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_step();
    t_hold();
    t_low_write();
    t_no_carry();
    t_jump();
    t_pop();
    step = 1; tick(); // move away from 0 before wrap test
    t_wrap();
    step = 1; tick();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule